// File: doc/BRIEF.md
# Scripted Bus Slave Responder

This block is a synthesizable Wishbone slave that stands in for a real peripheral when a bus master is under test. It does not decode addresses or store write data. Each request that the master places on the bus consumes the next entry of a script that the bench preloads through a small append-only load port. The entry decides how the slave answers that request. An entry holds a response kind (acknowledge, error or retry), a wait style (hold the request off with STALL, or take it and answer late), a wait length, and a read data word.

Two build-time switches select whether the retry and stall outputs exist, which gives four configurations: minimal, retry-only, stall-only and full. A build without stall handles one request at a time, and the master holds STB until it sees a terminating response. A build with stall takes requests in pipelined fashion. It keeps the accepted ones in a pending queue and answers them strictly in order. When the script runs dry, every further request gets an error response and a sticky flag is raised.

Top module: `scripted_bus_slave`

## Requirements
- R1: While `rst` is high, `wb_ack`, `wb_err` and `wb_rty` are low. After reset the script is empty, `wb_stall` is low and `script_done` is low.
- R2: At most one of `wb_ack`, `wb_err` and `wb_rty` is high in any cycle.
- R3: A request is taken only in a cycle with `wb_cyc` and `wb_stb` both high. Script entries are consumed one per taken request, in load order. For an entry with the delayed-response style and wait length N, the terminating pulse appears N+2 cycles after the cycle in which the request was taken, when it is at the head of the pending queue.
- R4: Response kind code 0 gives ACK and code 1 gives ERR. Code 2 gives RTY when retry is built in and ERR otherwise. Code 3 gives ERR.
- R5: A build without retry never raises `wb_rty`. A build without stall never raises `wb_stall`, and in that build a stall-style entry is treated as a response delay of the same length.
- R6: In a stall build, a stall-style entry of length N keeps `wb_stall` high during the first N cycles in which a request is presented, and the request is taken in the cycle after. Its response then follows with no added delay.
- R7: In a stall build, up to QDEPTH taken requests may be pending. Their answers come back in acceptance order. `wb_stall` is high while the queue is full.
- R8: A request taken while the script is empty is answered with ERR, and it sets `script_done`. The flag stays high until reset, even after new entries are loaded.
- R9: When `wb_cyc` falls, all pending responses are dropped and never answered. Their script entries remain consumed.
- R10: `wb_dat_r` carries the entry's data word only in a cycle with `wb_ack` high for a read (`wb_we` low when the request was taken). In every other cycle it is zero, including on the ACK of a write.
- R11: In a build without stall, no new request is taken while one is pending or its response is on the bus. A master that holds STB through its ACK cycle therefore receives exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Append one entry to the script; ignored while the script is full |
| ld_kind | input | 2 | Response kind code of the loaded entry (0 ACK, 1 ERR, 2 RTY, 3 ERR) |
| ld_stall_wait | input | 1 | 1: wait is a stall before taking; 0: wait is a response delay |
| ld_wait | input | WAIT_W | Wait length in cycles |
| ld_data | input | DW | Read data returned with ACK |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Request strobe |
| wb_we | input | 1 | Write request |
| wb_adr | input | AW | Address (not decoded) |
| wb_dat_w | input | DW | Write data (not stored) |
| wb_sel | input | SW | Byte selects (not used) |
| wb_dat_r | output | DW | Read data, nonzero only with a read ACK |
| wb_ack | output | 1 | Acknowledge pulse |
| wb_err | output | 1 | Error pulse |
| wb_rty | output | 1 | Retry pulse, tied low without retry |
| wb_stall | output | 1 | Stall, tied low without stall |
| script_done | output | 1 | Sticky flag: a request found the script empty |

## Verification
The full build is tracked against a queue-based model on every clock. The bench targets five corner cases. A full pending queue that failed to raise stall would drop or reorder answers. A stall-style entry that was counted while STB was low would let the request in early. A CYC drop that kept pending entries alive would later release stray pulses. An empty script that stalled instead of erroring would hang the master. The minimal build is driven with STB held through the response. A slave that re-sampled that held strobe would answer twice, and one that kept retry enabled would leak a RTY pulse.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        RK_ACK  = 2'd0,
        RK_ERR  = 2'd1,
        RK_RTY  = 2'd2,
        RK_RSVD = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        rsp_kind_e kind;
        logic      stall_wait;
    } script_ctl_t;

    typedef struct packed {
        logic ack;
        logic err;
        logic rty;
    } term_t;

    // map a scripted code to what this build can actually signal
    function automatic rsp_kind_e fold_kind(rsp_kind_e k, bit rty_ok);
        if (k == RK_ACK)            return RK_ACK;
        if (k == RK_RTY && rty_ok)  return RK_RTY;
        return RK_ERR;
    endfunction

    function automatic term_t decode_term(rsp_kind_e k);
        term_t t;
        t.ack = (k == RK_ACK);
        t.rty = (k == RK_RTY);
        t.err = (k == RK_ERR) || (k == RK_RSVD);
        return t;
    endfunction

endpackage

// File: rtl/sbs_script_store.sv
module sbs_script_store
    import sbs_pkg::*;
#(
    parameter int DW     = 16,
    parameter int WAIT_W = 4,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  script_ctl_t       ld_ctl,
    input  logic [WAIT_W-1:0] ld_wait,
    input  logic [DW-1:0]     ld_data,
    input  logic              take,
    output logic              hd_valid,
    output script_ctl_t       hd_ctl,
    output logic [WAIT_W-1:0] hd_wait,
    output logic [DW-1:0]     hd_data
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL_OCC = (PW+1)'(DEPTH);

    script_ctl_t       ctl_mem  [DEPTH];
    logic [WAIT_W-1:0] wait_mem [DEPTH];
    logic [DW-1:0]     data_mem [DEPTH];

    logic [PW:0] wr_q, rd_q, occ;
    logic        wr_ok;

    assign occ      = wr_q - rd_q;
    assign wr_ok    = ld_en && (occ != FULL_OCC);
    assign hd_valid = (occ != '0);
    assign hd_ctl   = ctl_mem[rd_q[PW-1:0]];
    assign hd_wait  = wait_mem[rd_q[PW-1:0]];
    assign hd_data  = data_mem[rd_q[PW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (wr_ok)            wr_q <= wr_q + 1'b1;
            if (take && hd_valid) rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !rst) begin
            ctl_mem[wr_q[PW-1:0]]  <= ld_ctl;
            wait_mem[wr_q[PW-1:0]] <= ld_wait;
            data_mem[wr_q[PW-1:0]] <= ld_data;
        end
    end

endmodule

// File: rtl/sbs_pend_fifo.sv
module sbs_pend_fifo
    import sbs_pkg::*;
#(
    parameter int DW     = 16,
    parameter int WAIT_W = 4,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  rsp_kind_e         push_kind,
    input  logic [WAIT_W-1:0] push_delay,
    input  logic [DW-1:0]     push_data,
    input  logic              pop,
    output logic              full,
    output logic              empty,
    output rsp_kind_e         hd_kind,
    output logic [WAIT_W-1:0] hd_delay,
    output logic [DW-1:0]     hd_data
);
    localparam int QW = $clog2(QDEPTH);
    localparam logic [QW:0] FULL_OCC = (QW+1)'(QDEPTH);

    rsp_kind_e         kind_mem  [QDEPTH];
    logic [WAIT_W-1:0] delay_mem [QDEPTH];
    logic [DW-1:0]     data_mem  [QDEPTH];

    logic [QW:0] wr_q, rd_q, occ;

    assign occ      = wr_q - rd_q;
    assign full     = (occ == FULL_OCC);
    assign empty    = (occ == '0);
    assign hd_kind  = kind_mem[rd_q[QW-1:0]];
    assign hd_delay = delay_mem[rd_q[QW-1:0]];
    assign hd_data  = data_mem[rd_q[QW-1:0]];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (push && !full) wr_q <= wr_q + 1'b1;
            if (pop && !empty) rd_q <= rd_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !rst && !flush) begin
            kind_mem[wr_q[QW-1:0]]  <= push_kind;
            delay_mem[wr_q[QW-1:0]] <= push_delay;
            data_mem[wr_q[QW-1:0]]  <= push_data;
        end
    end

endmodule

// File: rtl/scripted_bus_slave.sv
module scripted_bus_slave
    import sbs_pkg::*;
#(
    parameter bit HAS_RETRY = 1'b1,
    parameter bit HAS_STALL = 1'b1,
    parameter int DW        = 16,
    parameter int AW        = 8,
    parameter int SW        = DW / 8,
    parameter int WAIT_W    = 4,
    parameter int DEPTH     = 16,
    parameter int QDEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [1:0]        ld_kind,
    input  logic              ld_stall_wait,
    input  logic [WAIT_W-1:0] ld_wait,
    input  logic [DW-1:0]     ld_data,
    input  logic              wb_cyc,
    input  logic              wb_stb,
    input  logic              wb_we,
    input  logic [AW-1:0]     wb_adr,
    input  logic [DW-1:0]     wb_dat_w,
    input  logic [SW-1:0]     wb_sel,
    output logic [DW-1:0]     wb_dat_r,
    output logic              wb_ack,
    output logic              wb_err,
    output logic              wb_rty,
    output logic              wb_stall,
    output logic              script_done
);
    script_ctl_t       ld_ctl, hd_ctl;
    logic              hd_valid;
    logic [WAIT_W-1:0] hd_wait;
    logic [DW-1:0]     hd_data;

    logic              q_full, q_empty, q_pop;
    rsp_kind_e         qh_kind, push_kind;
    logic [WAIT_W-1:0] qh_delay, push_delay;
    logic [DW-1:0]     qh_data, push_data;

    logic              req, accept, script_hold, stall_w, on_bus;
    logic [WAIT_W-1:0] spent_q, hcnt_q;
    term_t             term_q;
    logic [DW-1:0]     dat_q;
    logic              done_q;

    assign ld_ctl.kind       = rsp_kind_e'(ld_kind);
    assign ld_ctl.stall_wait = ld_stall_wait;

    sbs_script_store #(.DW(DW), .WAIT_W(WAIT_W), .DEPTH(DEPTH)) u_script (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_ctl   (ld_ctl),
        .ld_wait  (ld_wait),
        .ld_data  (ld_data),
        .take     (accept),
        .hd_valid (hd_valid),
        .hd_ctl   (hd_ctl),
        .hd_wait  (hd_wait),
        .hd_data  (hd_data)
    );

    assign req    = wb_cyc & wb_stb;
    assign on_bus = term_q.ack | term_q.err | term_q.rty;

    generate
        if (HAS_STALL) begin : g_pipelined
            // hold off while a stall-style head entry has time left, or no room
            assign script_hold = hd_valid && hd_ctl.stall_wait && (spent_q < hd_wait);
            assign stall_w     = script_hold | q_full;
            assign accept      = req & ~stall_w;
        end else begin : g_single
            assign script_hold = 1'b0;
            assign stall_w     = 1'b0;
            assign accept      = req & q_empty & ~on_bus;
        end
    endgenerate

    assign push_kind  = hd_valid ? fold_kind(hd_ctl.kind, HAS_RETRY) : RK_ERR;
    assign push_delay = (hd_valid && !(HAS_STALL && hd_ctl.stall_wait)) ? hd_wait : '0;
    assign push_data  = (hd_valid && !wb_we) ? hd_data : '0;
    assign q_pop      = wb_cyc && !q_empty && (hcnt_q == qh_delay);

    sbs_pend_fifo #(.DW(DW), .WAIT_W(WAIT_W), .QDEPTH(QDEPTH)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .flush      (~wb_cyc),
        .push       (accept),
        .push_kind  (push_kind),
        .push_delay (push_delay),
        .push_data  (push_data),
        .pop        (q_pop),
        .full       (q_full),
        .empty      (q_empty),
        .hd_kind    (qh_kind),
        .hd_delay   (qh_delay),
        .hd_data    (qh_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            spent_q <= '0;
            hcnt_q  <= '0;
            term_q  <= '0;
            dat_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            term_q <= '0;
            dat_q  <= '0;
            if (!wb_cyc) begin
                hcnt_q  <= '0;
                spent_q <= '0;
            end else begin
                if (!q_empty) begin
                    if (q_pop) begin
                        term_q <= decode_term(qh_kind);
                        dat_q  <= (qh_kind == RK_ACK) ? qh_data : '0;
                        hcnt_q <= '0;
                    end else begin
                        hcnt_q <= hcnt_q + 1'b1;
                    end
                end
                if (accept) begin
                    spent_q <= '0;
                    if (!hd_valid) done_q <= 1'b1;
                end else if (req && script_hold) begin
                    spent_q <= spent_q + 1'b1;
                end
            end
        end
    end

    assign wb_ack      = term_q.ack & ~rst;
    assign wb_err      = term_q.err & ~rst;
    assign wb_rty      = HAS_RETRY ? (term_q.rty & ~rst) : 1'b0;
    assign wb_stall    = stall_w;
    assign wb_dat_r    = wb_ack ? dat_q : '0;
    assign script_done = done_q;

endmodule

// File: rtl/sbs_checks.sv
module sbs_checks #(
    parameter bit HAS_RETRY = 1'b1,
    parameter bit HAS_STALL = 1'b1,
    parameter int DW        = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          wb_cyc,
    input logic          wb_ack,
    input logic          wb_err,
    input logic          wb_rty,
    input logic          wb_stall,
    input logic [DW-1:0] wb_dat_r,
    input logic          script_done
);
    logic any_term;
    assign any_term = wb_ack | wb_err | wb_rty;

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |-> !any_term);

    a_r2_one_term: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wb_ack, wb_err, wb_rty}));

    a_r5_rty_absent: assert property (@(posedge clk) disable iff (rst)
        !HAS_RETRY |-> !wb_rty);

    a_r5_stall_absent: assert property (@(posedge clk) disable iff (rst)
        !HAS_STALL |-> !wb_stall);

    a_r10_dat_only_on_ack: assert property (@(posedge clk) disable iff (rst)
        !wb_ack |-> (wb_dat_r == '0));

    a_r9_term_needs_cycle: assert property (@(posedge clk) disable iff (rst)
        any_term |-> $past(wb_cyc));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
        script_done |=> script_done);

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (!HAS_STALL && any_term) |=> !any_term);

endmodule

bind scripted_bus_slave sbs_checks #(
    .HAS_RETRY (HAS_RETRY),
    .HAS_STALL (HAS_STALL),
    .DW        (DW)
) u_sbs_checks (
    .clk         (clk),
    .rst         (rst),
    .wb_cyc      (wb_cyc),
    .wb_ack      (wb_ack),
    .wb_err      (wb_err),
    .wb_rty      (wb_rty),
    .wb_stall    (wb_stall),
    .wb_dat_r    (wb_dat_r),
    .script_done (script_done)
);

// File: tb/test_scripted_bus_slave.sv
module test_scripted_bus_slave;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad   = 0;

    // full build signals
    logic          f_ld_en = 0, f_ld_sw = 0, f_cyc = 0, f_stb = 0, f_we = 0;
    logic [1:0]    f_ld_kind = 0;
    logic [WW-1:0] f_ld_wait = 0;
    logic [DW-1:0] f_ld_data = 0, f_dat_r;
    logic          f_ack, f_err, f_rty, f_stall, f_done;
    // minimal build signals
    logic          m_ld_en = 0, m_ld_sw = 0, m_cyc = 0, m_stb = 0, m_we = 0;
    logic [1:0]    m_ld_kind = 0;
    logic [WW-1:0] m_ld_wait = 0;
    logic [DW-1:0] m_ld_data = 0, m_dat_r;
    logic          m_ack, m_err, m_rty, m_stall, m_done;

    scripted_bus_slave #(.HAS_RETRY(1'b1), .HAS_STALL(1'b1), .DW(DW), .AW(AW),
                         .WAIT_W(WW), .DEPTH(16), .QDEPTH(4)) i_scripted_bus_slave (
        .clk(clk), .rst(rst), .ld_en(f_ld_en), .ld_kind(f_ld_kind), .ld_stall_wait(f_ld_sw),
        .ld_wait(f_ld_wait), .ld_data(f_ld_data), .wb_cyc(f_cyc), .wb_stb(f_stb), .wb_we(f_we),
        .wb_adr('0), .wb_dat_w('0), .wb_sel('0), .wb_dat_r(f_dat_r), .wb_ack(f_ack),
        .wb_err(f_err), .wb_rty(f_rty), .wb_stall(f_stall), .script_done(f_done));

    scripted_bus_slave #(.HAS_RETRY(1'b0), .HAS_STALL(1'b0), .DW(DW), .AW(AW),
                         .WAIT_W(WW), .DEPTH(16), .QDEPTH(4)) i_scripted_bus_slave_min (
        .clk(clk), .rst(rst), .ld_en(m_ld_en), .ld_kind(m_ld_kind), .ld_stall_wait(m_ld_sw),
        .ld_wait(m_ld_wait), .ld_data(m_ld_data), .wb_cyc(m_cyc), .wb_stb(m_stb), .wb_we(m_we),
        .wb_adr('0), .wb_dat_w('0), .wb_sel('0), .wb_dat_r(m_dat_r), .wb_ack(m_ack),
        .wb_err(m_err), .wb_rty(m_rty), .wb_stall(m_stall), .script_done(m_done));

    task automatic chk(string rq, int act, int exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference for the full build ----------------
    typedef struct { int kind; bit sw; int wt; int data; } ent_t;
    typedef struct { int kind; int dly; int data; } pnd_t;
    ent_t scr[$];
    pnd_t pq[$];
    int   hcnt = 0, spent = 0, p_code = 0, p_data = 0;
    bit   mdone = 0, armed = 0;

    function automatic bit model_stall();
        bit hold = (scr.size() > 0) && scr[0].sw && (spent < scr[0].wt);
        return hold || (pq.size() == 4);
    endfunction

    always @(posedge clk) begin
        bit st, rq, acc;
        int nk, nd;
        st = model_stall();
        rq = f_cyc && f_stb;
        acc = rq && !st;
        nk = 0; nd = 0;
        if (rst) begin
            scr.delete(); pq.delete();
            hcnt = 0; spent = 0; mdone = 0; armed = 1;
        end else begin
            if (!f_cyc) begin
                pq.delete(); hcnt = 0; spent = 0;
            end else begin
                if (pq.size() > 0) begin
                    if (hcnt == pq[0].dly) begin
                        nk = pq[0].kind + 1;
                        nd = (pq[0].kind == 0) ? pq[0].data : 0;
                        void'(pq.pop_front());
                        hcnt = 0;
                    end else hcnt++;
                end
                if (acc) begin
                    pnd_t e;
                    if (scr.size() > 0) begin
                        e.kind = (scr[0].kind == 3) ? 1 : scr[0].kind;
                        e.dly  = scr[0].sw ? 0 : scr[0].wt;
                        e.data = f_we ? 0 : scr[0].data;
                        void'(scr.pop_front());
                    end else begin
                        e.kind = 1; e.dly = 0; e.data = 0; mdone = 1;
                    end
                    pq.push_back(e);
                    spent = 0;
                end else if (rq && scr.size() > 0 && scr[0].sw && spent < scr[0].wt) begin
                    spent++;
                end
            end
            if (f_ld_en && scr.size() < 16) begin
                ent_t n;
                n.kind = int'(f_ld_kind); n.sw = f_ld_sw; n.wt = int'(f_ld_wait); n.data = int'(f_ld_data);
                scr.push_back(n);
            end
        end
        p_code = nk; p_data = nd;
    end

    // response logs
    typedef struct { int code; int data; } rsp_t;
    rsp_t fresp[$];
    rsp_t mresp[$];

    always @(negedge clk) begin
        #1;
        if (armed && !rst) begin
            // R3: terminating pulses match the model every cycle
            chk("R3", {29'd0, f_ack, f_err, f_rty},
                {29'd0, p_code == 1, p_code == 2, p_code == 3}, "full term pulses");
            chk("R6", int'(f_stall), int'(model_stall()), "full stall");
            chk("R10", int'(f_dat_r), p_data, "full read data");
            chk("R8", int'(f_done), int'(mdone), "full done flag");
            chk("R5", int'(m_stall | m_rty), 0, "minimal stall/rty");
            chk("R2", int'(f_ack) + int'(f_err) + int'(f_rty) <= 1, 1, "full one-hot");
            if (f_ack | f_err | f_rty) fresp.push_back('{f_ack ? 1 : (f_err ? 2 : 3), int'(f_dat_r)});
            if (m_ack | m_err | m_rty) mresp.push_back('{m_ack ? 1 : (m_err ? 2 : 3), int'(m_dat_r)});
        end
    end

    // ---------------- drive tasks ----------------
    task automatic f_load(int kind, bit sw, int wt, int data);
        f_ld_en = 1; f_ld_kind = 2'(kind); f_ld_sw = sw; f_ld_wait = WW'(wt); f_ld_data = DW'(data);
        @(negedge clk);
        f_ld_en = 0;
    endtask

    task automatic m_load(int kind, bit sw, int wt, int data);
        m_ld_en = 1; m_ld_kind = 2'(kind); m_ld_sw = sw; m_ld_wait = WW'(wt); m_ld_data = DW'(data);
        @(negedge clk);
        m_ld_en = 0;
    endtask

    // present one request; returns at the negedge after it was taken, STB still high
    task automatic f_issue(bit we, output int stalls);
        f_cyc = 1; f_stb = 1; f_we = we; stalls = 0;
        forever begin
            bit s = f_stall;
            @(posedge clk);
            if (!s) break;
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic f_idle(int n);
        f_stb = 0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_f(string rq, int idx, int code, int data);
        if (fresp.size() > idx) begin
            chk(rq, fresp[idx].code, code, $sformatf("full response %0d kind", idx));
            chk(rq, fresp[idx].data, data, $sformatf("full response %0d data", idx));
        end else chk(rq, fresp.size(), idx + 1, "full response count");
    endtask

    // minimal build: hold STB until a response is seen; returns cycles to the pulse
    task automatic m_req(bit we, output int lat);
        m_cyc = 1; m_stb = 1; m_we = we; lat = 0;
        do begin
            @(negedge clk); #1;
            lat++;
        end while (!(m_ack | m_err | m_rty) && lat < 40);
        m_stb = 0;
    endtask

    initial begin : wd
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int st, n, lat;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", {29'd0, f_ack, f_err, f_rty}, 0, "terms low in reset");
        chk("R1", {30'd0, m_ack, m_err}, 0, "minimal terms low in reset");
        rst = 0;
        @(negedge clk); #1;
        chk("R1", int'(f_stall), 0, "stall low after reset");
        chk("R1", int'(f_done), 0, "done low after reset");

        // script: E0 ACK dly1, E1 ERR, E2 RTY dly2, E3 ACK stall3, E4 ACK read, E5 ACK write
        f_load(0, 0, 1, 16'h1111);
        f_load(1, 0, 0, 16'hBAD1);
        f_load(2, 0, 2, 16'hBAD2);
        f_load(0, 1, 3, 16'h2222);
        f_load(0, 0, 0, 16'h3333);
        f_load(0, 0, 0, 16'h4444);
        f_cyc = 1;

        // R3: latency N+2 for a delayed response
        fresp.delete();
        f_issue(0, st);
        f_stb = 0; n = 1; #1;
        while (!(f_ack | f_err | f_rty) && n < 20) begin @(negedge clk); #1; n++; end
        chk("R3", n, 3, "latency for wait 1");
        f_idle(4);
        expect_f("R3", 0, 1, 16'h1111);

        // R4/R7: ERR then RTY pipelined, in order
        fresp.delete();
        f_issue(0, st);
        f_issue(0, st);
        f_idle(8);
        expect_f("R4", 0, 2, 0);
        expect_f("R4", 1, 3, 0);

        // R6: stall-style entry holds the request 3 cycles
        fresp.delete();
        f_issue(0, st);
        chk("R6", st, 3, "stall cycles before taking");
        f_idle(5);
        expect_f("R6", 0, 1, 16'h2222);

        // R10: read returns data, write ACK returns zero
        fresp.delete();
        f_issue(0, st);
        f_issue(1, st);
        f_idle(6);
        expect_f("R10", 0, 1, 16'h3333);
        expect_f("R10", 1, 1, 0);

        // R7: queue full raises stall, order kept
        for (int i = 0; i < 6; i++) f_load(0, 0, 3, 16'h0A10 + i);
        fresp.delete();
        n = 0;
        for (int i = 0; i < 6; i++) begin f_issue(0, st); n += st; end
        f_idle(30);
        chk("R7", int'(n > 0), 1, "stall on full queue");
        for (int i = 0; i < 6; i++) expect_f("R7", i, 1, 16'h0A10 + i);

        // R9: CYC drop discards pending, entries stay consumed
        f_load(0, 0, 5, 16'hAAAA);
        f_load(0, 0, 5, 16'hBBBB);
        f_load(0, 0, 0, 16'hCCCC);
        fresp.delete();
        f_issue(0, st);
        f_issue(0, st);
        f_stb = 0; f_cyc = 0;
        repeat (12) @(negedge clk);
        chk("R9", fresp.size(), 0, "no pulses after cyc drop");
        f_cyc = 1;
        f_issue(0, st);
        f_idle(5);
        expect_f("R9", 0, 1, 16'hCCCC);

        // R8: empty script gives ERR and a sticky flag
        fresp.delete();
        f_issue(0, st);
        f_idle(4);
        expect_f("R8", 0, 2, 0);
        chk("R8", int'(f_done), 1, "done set");
        f_load(0, 0, 0, 16'hDDDD);
        f_issue(0, st);
        f_idle(4);
        expect_f("R8", 1, 1, 16'hDDDD);
        chk("R8", int'(f_done), 1, "done still set");

        // minimal build: RTY folds to ERR, stall entry acts as delay, single pulse
        m_load(2, 0, 0, 16'h0);
        m_load(0, 1, 2, 16'h5555);
        m_load(0, 0, 0, 16'h6666);
        m_cyc = 1;
        mresp.delete();
        m_req(0, lat);
        @(negedge clk);
        m_req(0, lat);
        chk("R5", lat, 4, "stall entry as delay in minimal");
        @(negedge clk);
        m_req(0, lat);
        repeat (5) @(negedge clk);
        chk("R11", mresp.size(), 3, "one pulse per held request");
        if (mresp.size() == 3) begin
            chk("R4", mresp[0].code, 2, "RTY folds to ERR");
            chk("R5", mresp[1].data, 16'h5555, "delayed data");
            chk("R11", mresp[2].data, 16'h6666, "held strobe data");
        end
        m_req(0, lat);
        repeat (3) @(negedge clk);
        chk("R8", int'(m_done), 1, "minimal done set");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule